// File: doc/BRIEF.md
# Masked Block-Write Datapath

This block is the write path in front of a four-bit-wide memory array. Each cycle it takes one command and turns it into a registered write request for the array. The request holds a base column, a per-column lane enable, a per-bit enable and the data. Three kinds of write are supported:

- A plain write stores the input data at one column with all bits enabled.
- A masked write stores the input data at one column. Only the bits that the selected mask allows are written.
- A block write copies an internal four-bit color value into any subset of four adjacent columns in a single cycle. The pattern on the data input chooses the columns, so up to sixteen bits change per cycle.

Two internal registers support these writes. The color register holds the block-write value. The persistent mask register holds the bit mask used by masked and block writes. Each is loaded by its own command, which takes the value from the data input. A masked or block write can instead carry its own mask for that cycle only, by raising the new-mask flag.

The request appears on the outputs one clock after the command is sampled. The memory array is written by the consumer of these outputs. Row timing, refresh and page sequencing belong to other blocks.

Top module: `blkw_datapath`

## Requirements
- R1: While reset is asserted and after it is released with no command, `wr_en`, `wr_col`, `wr_lane_en`, `wr_bit_en` and `wr_data` are all zero. The color register resets to 0 and the persistent mask register resets to all ones.
- R2: Command code 1 (plain write) gives a request one cycle later with `wr_en`=1, `wr_col`=`col_addr`, `wr_lane_en`=0001, `wr_bit_en`=1111 and `wr_data`=`din`.
- R3: Command code 2 (masked write) gives the same column, lane and data as a plain write. Its `wr_bit_en` is `mask_in` when `new_mask` is 1, and the stored persistent mask otherwise. A mask bit of 1 lets that data bit be written; 0 keeps the old bit.
- R4: Command code 5 (load mask) stores `din` into the persistent mask register. It produces no write in the following cycle.
- R5: Command code 4 (load color) stores `din` into the color register. It produces no write in the following cycle.
- R6: Command code 3 (block write) gives `wr_lane_en`=`din`, where bit i enables column `wr_col`+i. It also gives `wr_data`=the color register and `wr_bit_en` selected as in R3. When `din` is 0 no write is issued and all outputs are zero.
- R7: In a block write the two low bits of `col_addr` are ignored: `wr_col` is `col_addr` with bits 1:0 cleared.
- R8: Codes 0, 6 and 7 produce no write and leave both internal registers unchanged. Whenever `wr_en` is 0, the lane enable, bit enable, column and data outputs are zero.
- R9: `new_mask` never changes the stored mask, and has no effect on plain writes or load commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | Command: 0 idle, 1 write, 2 masked write, 3 block write, 4 load color, 5 load mask |
| new_mask | input | 1 | Use `mask_in` instead of the stored mask for this cycle |
| col_addr | input | 9 | Column address |
| din | input | 4 | Write data, column-select pattern, or register load value |
| mask_in | input | 4 | Per-cycle bit mask |
| wr_en | output | 1 | Write request valid |
| wr_col | output | 9 | Base column of the request |
| wr_lane_en | output | 4 | Per-column enable relative to `wr_col` |
| wr_bit_en | output | 4 | Per-bit write enable |
| wr_data | output | 4 | Data written to every enabled column |

## Verification
The assertions assume that `op_code`, `din`, `mask_in` and `new_mask` are stable around each rising edge. They also assume that the request seen one cycle after a command depends only on that command and on earlier register loads. The bench changes inputs only on the falling edge, so every command is sampled cleanly at exactly one edge. The random stimulus draws all eight command codes, including the unused ones, so the assertions see every kind of write. Directed cases cover the values just after reset, columns at the top of the range with the low bits set, an empty block-write pattern, and the override mask followed by a return to the stored mask.

// File: rtl/blkw_pkg.sv
package blkw_pkg;
  typedef enum logic [2:0] {
    OP_IDLE         = 3'd0,
    OP_WRITE        = 3'd1,
    OP_WRITE_MASKED = 3'd2,
    OP_BLOCK_WRITE  = 3'd3,
    OP_LOAD_COLOR   = 3'd4,
    OP_LOAD_MASK    = 3'd5
  } op_e;
endpackage

// File: rtl/blkw_regs.sv
module blkw_regs #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_color,
  input  logic              load_mask,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] color_q,
  output logic [DATA_W-1:0] mask_q
);
  logic [DATA_W-1:0] color_d, mask_d;
  logic              color_en, mask_en;

  always_comb begin
    color_en = load_color;
    mask_en  = load_mask;
    color_d  = din;
    mask_d   = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      color_q <= '0;
      mask_q  <= '1;
    end else begin
      if (color_en) color_q <= color_d;
      if (mask_en)  mask_q  <= mask_d;
    end
  end
endmodule

// File: rtl/blkw_mask_sel.sv
module blkw_mask_sel #(
  parameter int DATA_W = 4
) (
  input  logic              apply_mask,
  input  logic              new_mask,
  input  logic [DATA_W-1:0] mask_in,
  input  logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] bit_en
);
  always_comb begin
    if (!apply_mask)   bit_en = '1;
    else if (new_mask) bit_en = mask_in;
    else               bit_en = mask_q;
  end
endmodule

// File: rtl/blkw_col_gen.sv
module blkw_col_gen #(
  parameter int DATA_W = 4,
  parameter int COLS   = 512,
  localparam int COL_W  = $clog2(COLS),
  localparam int LANE_W = $clog2(DATA_W)
) (
  input  logic              single_col,
  input  logic              block_col,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [DATA_W-1:0] sel,
  output logic [COL_W-1:0]  col_base,
  output logic [DATA_W-1:0] lane_en
);
  always_comb begin
    col_base = col_addr;
    if (block_col) col_base[LANE_W-1:0] = '0;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign lane_en[i] = block_col ? sel[i] : single_col;
    end else begin : g_rest
      assign lane_en[i] = block_col & sel[i];
    end
  end
endmodule

// File: rtl/blkw_datapath.sv
module blkw_datapath
  import blkw_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int COLS   = 512,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic              new_mask,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] mask_in,
  output logic              wr_en,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_lane_en,
  output logic [DATA_W-1:0] wr_bit_en,
  output logic [DATA_W-1:0] wr_data
);
  op_e               op;
  logic              is_plain, is_masked, is_block;
  logic              ld_color, ld_mask;
  logic [DATA_W-1:0] color_q, mask_q, sel_bits;
  logic [COL_W-1:0]  base_c;
  logic [DATA_W-1:0] lane_c;

  logic              en_d;
  logic [COL_W-1:0]  col_d;
  logic [DATA_W-1:0] lane_d, bit_d, data_d;

  always_comb begin
    op        = op_e'(op_code);
    is_plain  = (op == OP_WRITE);
    is_masked = (op == OP_WRITE_MASKED);
    is_block  = (op == OP_BLOCK_WRITE);
    ld_color  = (op == OP_LOAD_COLOR);
    ld_mask   = (op == OP_LOAD_MASK);
  end

  blkw_regs #(.DATA_W(DATA_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_color (ld_color),
    .load_mask  (ld_mask),
    .din        (din),
    .color_q    (color_q),
    .mask_q     (mask_q)
  );

  blkw_mask_sel #(.DATA_W(DATA_W)) msel_i (
    .apply_mask (is_masked | is_block),
    .new_mask   (new_mask),
    .mask_in    (mask_in),
    .mask_q     (mask_q),
    .bit_en     (sel_bits)
  );

  blkw_col_gen #(.DATA_W(DATA_W), .COLS(COLS)) cgen_i (
    .single_col (is_plain | is_masked),
    .block_col  (is_block),
    .col_addr   (col_addr),
    .sel        (din),
    .col_base   (base_c),
    .lane_en    (lane_c)
  );

  always_comb begin
    en_d   = |lane_c;
    col_d  = '0;
    lane_d = '0;
    bit_d  = '0;
    data_d = '0;
    if (en_d) begin
      col_d  = base_c;
      lane_d = lane_c;
      bit_d  = sel_bits;
      data_d = is_block ? color_q : din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en      <= 1'b0;
      wr_col     <= '0;
      wr_lane_en <= '0;
      wr_bit_en  <= '0;
      wr_data    <= '0;
    end else begin
      wr_en      <= en_d;
      wr_col     <= col_d;
      wr_lane_en <= lane_d;
      wr_bit_en  <= bit_d;
      wr_data    <= data_d;
    end
  end
endmodule

// File: rtl/blkw_datapath_chk.sv
module blkw_datapath_chk
  import blkw_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int COLS   = 512,
  localparam int COL_W = $clog2(COLS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_code,
  input logic              new_mask,
  input logic [COL_W-1:0]  col_addr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] mask_in,
  input logic              wr_en,
  input logic [COL_W-1:0]  wr_col,
  input logic [DATA_W-1:0] wr_lane_en,
  input logic [DATA_W-1:0] wr_bit_en,
  input logic [DATA_W-1:0] wr_data
);
  AST_PLAIN_FULL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_code) == OP_WRITE |-> wr_en && wr_bit_en == '1 && wr_lane_en == 1 && wr_data == $past(din)); // R2

  AST_MASK_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_code) == OP_WRITE_MASKED && $past(new_mask)) |-> wr_bit_en == $past(mask_in)); // R3

  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_code) == OP_LOAD_MASK || $past(op_code) == OP_LOAD_COLOR) |-> !wr_en); // R4

  AST_BLOCK_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_code) == OP_BLOCK_WRITE |-> wr_lane_en == $past(din)); // R6

  AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_code) == OP_BLOCK_WRITE |-> wr_col[1:0] == 2'b00); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (wr_lane_en == '0 && wr_bit_en == '0 && wr_col == '0 && wr_data == '0)); // R8

  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_code) == OP_WRITE || $past(op_code) == OP_WRITE_MASKED) |-> $onehot0(wr_lane_en) && wr_lane_en[0]); // R2
endmodule

bind blkw_datapath blkw_datapath_chk #(.DATA_W(DATA_W), .COLS(COLS)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .new_mask(new_mask),
  .col_addr(col_addr), .din(din), .mask_in(mask_in), .wr_en(wr_en),
  .wr_col(wr_col), .wr_lane_en(wr_lane_en), .wr_bit_en(wr_bit_en), .wr_data(wr_data)
);

// File: tb/blkw_datapath_tb_top.sv
module blkw_datapath_tb_top;
  localparam real HALF = 2.5;

  logic       clk;
  logic       rst_n;
  logic [2:0] op_code;
  logic       new_mask;
  logic [8:0] col_addr;
  logic [3:0] din, mask_in;
  logic       wr_en;
  logic [8:0] wr_col;
  logic [3:0] wr_lane_en, wr_bit_en, wr_data;

  int checks = 0;
  int fails  = 0;
  logic [3:0] color_m, mask_m;

  blkw_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .new_mask(new_mask),
    .col_addr(col_addr), .din(din), .mask_in(mask_in), .wr_en(wr_en),
    .wr_col(wr_col), .wr_lane_en(wr_lane_en), .wr_bit_en(wr_bit_en), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  function automatic logic [21:0] pack_out(logic e, logic [8:0] c, logic [3:0] l,
                                           logic [3:0] b, logic [3:0] d);
    return {e, c, l, b, d};
  endfunction

  function automatic logic [21:0] expect_out(logic [2:0] op, logic nm, logic [8:0] col,
                                             logic [3:0] di, logic [3:0] mi);
    logic [3:0] m;
    m = nm ? mi : mask_m;
    case (op)
      3'd1: return pack_out(1'b1, col, 4'b0001, 4'hF, di);
      3'd2: return pack_out(1'b1, col, 4'b0001, m, di);
      3'd3: return (di == 4'h0) ? 22'd0 : pack_out(1'b1, col & 9'h1FC, di, m, color_m);
      default: return 22'd0;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] op, logic nm);
    case (op)
      3'd1: return nm ? "R9" : "R2";
      3'd2: return "R3";
      3'd3: return "R6/R7";
      3'd4: return "R5";
      3'd5: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [21:0] act, logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(logic [2:0] op, logic nm, logic [8:0] col, logic [3:0] di,
                       logic [3:0] mi, string req);
    logic [21:0] exp;
    @(negedge clk);
    op_code = op; new_mask = nm; col_addr = col; din = di; mask_in = mi;
    exp = expect_out(op, nm, col, di, mi);
    @(posedge clk);
    #1;
    check(req, pack_out(wr_en, wr_col, wr_lane_en, wr_bit_en, wr_data), exp);
    if (op == 3'd4) color_m = di;
    if (op == 3'd5) mask_m = di;
  endtask

  initial begin
    #(HALF * 2.0 * 200000.0);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [2:0] op;
    void'($urandom(32'd20240611));
    color_m = 4'h0; mask_m = 4'hF;
    rst_n = 1'b0; op_code = 3'd0; new_mask = 1'b0; col_addr = '0; din = '0; mask_in = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", pack_out(wr_en, wr_col, wr_lane_en, wr_bit_en, wr_data), 22'd0);
    @(negedge clk);
    rst_n = 1'b1;
    do_op(3'd0, 1'b0, 9'd0, 4'h0, 4'h0, "R1 idle after reset");
    do_op(3'd2, 1'b0, 9'd7, 4'h9, 4'h0, "R1 mask reset value");
    do_op(3'd3, 1'b0, 9'd4, 4'hF, 4'h0, "R1 color reset value");
    do_op(3'd1, 1'b0, 9'h1FF, 4'h6, 4'h0, "R2 plain write top column");
    do_op(3'd4, 1'b0, 9'd0, 4'hA, 4'h0, "R5 load color");
    do_op(3'd5, 1'b1, 9'd0, 4'h5, 4'h3, "R4 load mask");
    do_op(3'd3, 1'b0, 9'h1FF, 4'hA, 4'h0, "R7 block low bits ignored");
    do_op(3'd3, 1'b0, 9'h013, 4'h0, 4'h0, "R6 empty block pattern");
    do_op(3'd2, 1'b1, 9'd33, 4'hC, 4'h3, "R3 per-cycle mask override");
    do_op(3'd2, 1'b0, 9'd34, 4'hC, 4'h3, "R9 stored mask kept");
    do_op(3'd3, 1'b1, 9'd66, 4'h6, 4'h9, "R6 block with override mask");
    do_op(3'd1, 1'b1, 9'd5, 4'h3, 4'h0, "R9 plain write ignores mask");
    do_op(3'd0, 1'b1, 9'd5, 4'hE, 4'h0, "R8 idle code");
    do_op(3'd6, 1'b0, 9'd5, 4'hE, 4'h0, "R8 code 6");
    do_op(3'd7, 1'b1, 9'd5, 4'hE, 4'h1, "R8 code 7");
    do_op(3'd3, 1'b0, 9'd8, 4'hF, 4'h0, "R8 registers unchanged");
    for (int i = 0; i < 3000; i++) begin
      op = 3'($urandom_range(0, 7));
      do_op(op, 1'($urandom_range(0, 1)), 9'($urandom_range(0, 511)),
            4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), req_of(op, 1'b0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule